// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One 16-bit down-counting channel of a three-channel interval timer. The channel advances only on cycles where the count-clock enable is high. A gate input and a three-bit mode select six behaviours: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square-wave generator, and software- and gate-triggered strobes. A host loads an initial count together with a mode. The channel then drives a single output line and shows its live count.

A load does not change the count at once. The channel copies the initial count into its counter on the next enabled tick. Two exceptions apply. A rewrite that keeps the same periodic mode waits for the end of the current period. A gate rising edge in a retriggerable mode schedules a restart for the next enabled tick. Counting is always binary. Bus decoding, latching and interrupt handling belong to neighbouring logic.

Top module: `pit_chan`

## Requirements
- R1: After reset `count_o` is 0 and `out_o` is 0. The channel stays idle, with no counting and no output change, until the first load.
- R2: A loaded value of 0 means 65536. In mode 0 the count shows 0 at the start tick, then 65535. `out_o` rises exactly 65536 ticks after the start tick.
- R3: Mode codes 6 and 7 behave as modes 2 and 3.
- R4: Mode 0 (terminal-count flag): at the start tick the count shows N and `out_o` is 0. Each tick decrements the count. `out_o` goes high on the tick where the count reaches 0 and stays high. The count then wraps to 65535.
- R5: In modes 0, 2, 3 and 4 counting holds while `gate_i` is low. In modes 0 and 4 a gate rising edge does not restart the count.
- R6: Mode 1 (one-shot): `out_o` is low from the start tick until the count reaches 0, then it stays high. Counting continues whatever the gate level.
- R7: Mode 2 (rate): the count runs N down to 1, then reloads N. On each reload tick `out_o` is high for exactly one tick interval and low otherwise. With N=1 `out_o` stays high after the first tick.
- R8: Mode 3 (square wave) has period N. `out_o` is high for the first ceil(N/2) ticks and low for the rest. Let p be the internal phase, N..1. The count shows 2p-N while p > floor(N/2), and 2p otherwise.
- R9: Modes 4 and 5 (strobes): `out_o` is high for exactly one tick interval when the count first reaches 0. The count then wraps, and the pulse does not repeat.
- R10: A load that keeps a running periodic mode (2 or 3) takes effect at the next reload. Any other load restarts the count with the new value on the next enabled tick.
- R11: In modes 1, 2, 3 and 5 a `gate_i` rising edge restarts counting from the initial count on the following enabled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count clock enable, one tick per high cycle |
| gate_i | input | 1 | Gate: counting enable or retrigger, depending on the mode |
| load_i | input | 1 | Load strobe for the initial count and the mode |
| mode_i | input | 3 | Operating mode sampled with the load (6 and 7 alias 2 and 3) |
| load_val_i | input | 16 | Initial count (0 means 65536) |
| count_o | output | 16 | Live count value |
| out_o | output | 1 | Channel output line |

## Verification
A table of vectors loads each mode with small counts and samples the output at chosen elapsed tick counts. These include the tick just before terminal count, the terminal count itself and the tick after. This separates the sticky modes (0 and 1) from the pulsing modes (4 and 5). It also separates a reload from a wrap. Odd and even square-wave periods show the uneven split. Directed runs then do the following:
- drop and raise the gate in both gate-enabled and retriggered modes;
- rewrite the count mid-period in modes 0 and 2, to tell a deferred update from an immediate one;
- run a full 65536-tick window, to show that a loaded zero is the full range and that a strobe does not repeat after the wrap.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  typedef enum logic [2:0] {
    M_TC      = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // codes 6/7 alias the periodic modes
  function automatic mode_e norm_mode(input logic [2:0] m);
    case (m)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return mode_e'(m);
    endcase
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic is_retrig(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction

  function automatic logic gate_free(input mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

endpackage

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic               gate_i,
  input  logic               load_i,
  input  logic [2:0]         mode_i,
  input  logic [CNT_W-1:0]   load_val_i,
  output logic               tick_o,
  output logic               start_o,
  output mode_e              mode_o,
  output logic [CNT_W:0]     init_o
);

  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

  logic              gate_q, armed_q, pend_q;
  mode_e             mode_q;
  logic [FULL_W-1:0] init_q;

  mode_e mode_n;
  logic  gate_rise, load_restart, gate_restart, tick;

  assign mode_n       = norm_mode(mode_i);
  assign gate_rise    = gate_i & ~gate_q;
  // same periodic mode while running: defer to period end
  assign load_restart = load_i & ~(armed_q & (mode_n == mode_q) & is_periodic(mode_n));
  assign gate_restart = gate_rise & armed_q & is_retrig(mode_q);
  assign tick         = cnt_en_i & armed_q & (gate_i | gate_free(mode_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      mode_q  <= M_TC;
      init_q  <= '0;
    end else begin
      gate_q <= gate_i;
      pend_q <= (pend_q & ~tick) | load_restart | gate_restart;
      if (load_i) begin
        armed_q <= 1'b1;
        mode_q  <= mode_n;
        init_q  <= (load_val_i == '0) ? FULL_CNT : {1'b0, load_val_i};
      end
    end
  end

  assign tick_o  = tick;
  assign start_o = pend_q;
  assign mode_o  = mode_q;
  assign init_o  = init_q;

  // R2
  load_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (load_val_i == '0) |=> init_q == FULL_CNT);

  // R10
  rewrite_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !pend_q && load_i && is_periodic(mode_q) && (norm_mode(mode_i) == mode_q)
    && !(gate_rise && is_retrig(mode_q)) |=> !pend_q);

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q && !load_i |=> !armed_q && !tick_o);

endmodule

// File: rtl/pit_chan_core.sv
module pit_chan_core
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  mode_e            mode_i,
  input  logic [CNT_W:0]   init_i,
  output logic [CNT_W:0]   cnt_o,
  output logic [CNT_W:0]   per_o,
  output logic             out_o
);

  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] ONE  = FULL_W'(1);
  localparam logic [FULL_W-1:0] MAXV = {1'b0, {CNT_W{1'b1}}};

  logic [FULL_W-1:0] cnt_q, per_q;
  logic              tc_q, out_q;

  logic [FULL_W-1:0] wrap_nxt, per_step, sq_per;
  logic              hit, reload;

  assign wrap_nxt = (cnt_q == '0) ? MAXV : cnt_q - ONE;
  assign hit      = (wrap_nxt == '0) & ~tc_q;
  assign reload   = (cnt_q == ONE);
  assign per_step = reload ? init_i : cnt_q - ONE;
  assign sq_per   = reload ? init_i : per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      tc_q  <= 1'b0;
      out_q <= 1'b0;
    end else if (tick_i) begin
      if (start_i) begin
        cnt_q <= init_i;
        per_q <= init_i;
        tc_q  <= 1'b0;
        out_q <= (mode_i == M_SQUARE);
      end else begin
        unique case (mode_i)
          M_RATE: begin
            cnt_q <= per_step;
            if (reload) per_q <= init_i;
            out_q <= reload;
          end
          M_SQUARE: begin
            cnt_q <= per_step;
            per_q <= sq_per;
            out_q <= per_step > (sq_per >> 1);
          end
          M_TC, M_ONESHOT: begin
            cnt_q <= wrap_nxt;
            tc_q  <= tc_q | hit;
            out_q <= out_q | hit;
          end
          default: begin
            cnt_q <= wrap_nxt;
            tc_q  <= tc_q | hit;
            out_q <= hit;
          end
        endcase
      end
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
  assign out_o = out_q;

  // R4
  tc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_TC) && out_q && !(tick_i && start_i) |=> out_q);

  // R9
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == M_SWSTB) || (mode_i == M_HWSTB)) && out_q && tick_i |=> !out_q);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q) && $stable(out_q));

  // R7 R8
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && is_periodic(mode_i) && (per_q != '0) |-> (cnt_q != '0) && (cnt_q <= per_q));

endmodule

// File: rtl/pit_chan_view.sv
module pit_chan_view
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  mode_e            mode_i,
  input  logic [CNT_W:0]   cnt_i,
  input  logic [CNT_W:0]   per_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] dbl_w, hi_w;
  logic             hi_half;

  // square wave shows two steps per tick in each half
  assign dbl_w   = cnt_i[CNT_W-1:0] << 1;
  assign hi_w    = dbl_w - per_i[CNT_W-1:0];
  assign hi_half = cnt_i > (per_i >> 1);
  assign count_o = (mode_i == M_SQUARE) ? (hi_half ? hi_w : dbl_w) : cnt_i[CNT_W-1:0];

endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);

  logic           tick, start;
  mode_e          mode;
  logic [CNT_W:0] init, cnt, per;

  pit_chan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .cnt_en_i, .gate_i, .load_i, .mode_i, .load_val_i,
    .tick_o(tick), .start_o(start), .mode_o(mode), .init_o(init)
  );

  pit_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(start), .mode_i(mode), .init_i(init),
    .cnt_o(cnt), .per_o(per), .out_o
  );

  pit_chan_view #(.CNT_W(CNT_W)) u_view (
    .mode_i(mode), .cnt_i(cnt), .per_i(per), .count_o
  );

endmodule

// File: tb/pit_chan_tb_top.sv
`timescale 1ns/1ps
module pit_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic        gate = 1'b1;
  logic        load = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] load_val = 16'd0;
  logic [15:0] count;
  logic        out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pit_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .gate_i(gate), .load_i(load),
    .mode_i(mode), .load_val_i(load_val), .count_o(count), .out_o(out)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] n;
    logic [7:0]  d;
    logic [15:0] c;
    logic        o;
  } vec_t;

  localparam int NV = 34;
  // mode, initial count, elapsed ticks after start tick, expected count, expected out
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd5, 8'd0, 16'd5, 1'b0}, '{3'd0, 16'd5, 8'd4, 16'd1, 1'b0},
    '{3'd0, 16'd5, 8'd5, 16'd0, 1'b1}, '{3'd0, 16'd5, 8'd6, 16'd65535, 1'b1},
    '{3'd1, 16'd4, 8'd0, 16'd4, 1'b0}, '{3'd1, 16'd4, 8'd3, 16'd1, 1'b0},
    '{3'd1, 16'd4, 8'd4, 16'd0, 1'b1}, '{3'd1, 16'd4, 8'd5, 16'd65535, 1'b1},
    '{3'd2, 16'd3, 8'd0, 16'd3, 1'b0}, '{3'd2, 16'd3, 8'd2, 16'd1, 1'b0},
    '{3'd2, 16'd3, 8'd3, 16'd3, 1'b1}, '{3'd2, 16'd3, 8'd4, 16'd2, 1'b0},
    '{3'd2, 16'd3, 8'd6, 16'd3, 1'b1}, '{3'd2, 16'd1, 8'd0, 16'd1, 1'b0},
    '{3'd2, 16'd1, 8'd1, 16'd1, 1'b1},
    '{3'd3, 16'd5, 8'd0, 16'd5, 1'b1}, '{3'd3, 16'd5, 8'd1, 16'd3, 1'b1},
    '{3'd3, 16'd5, 8'd2, 16'd1, 1'b1}, '{3'd3, 16'd5, 8'd3, 16'd4, 1'b0},
    '{3'd3, 16'd5, 8'd4, 16'd2, 1'b0}, '{3'd3, 16'd5, 8'd5, 16'd5, 1'b1},
    '{3'd3, 16'd4, 8'd1, 16'd2, 1'b1}, '{3'd3, 16'd4, 8'd2, 16'd4, 1'b0},
    '{3'd4, 16'd3, 8'd0, 16'd3, 1'b0}, '{3'd4, 16'd3, 8'd2, 16'd1, 1'b0},
    '{3'd4, 16'd3, 8'd3, 16'd0, 1'b1}, '{3'd4, 16'd3, 8'd4, 16'd65535, 1'b0},
    '{3'd5, 16'd2, 8'd2, 16'd0, 1'b1}, '{3'd5, 16'd2, 8'd3, 16'd65535, 1'b0},
    '{3'd6, 16'd2, 8'd0, 16'd2, 1'b0}, '{3'd6, 16'd2, 8'd1, 16'd1, 1'b0},
    '{3'd6, 16'd2, 8'd2, 16'd2, 1'b1}, '{3'd6, 16'd2, 8'd3, 16'd1, 1'b0},
    '{3'd7, 16'd4, 8'd2, 16'd4, 1'b0}
  };

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0:       return "R4";
      3'd1:       return "R6";
      3'd2:       return "R7";
      3'd3:       return "R8";
      3'd4, 3'd5: return "R9";
      default:    return "R3";
    endcase
  endfunction

  task automatic adv(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gate = 1'b1; cnt_en = 1'b1; load = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    load = 1'b1; mode = m; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [15:0] exp_c, input logic exp_o);
    n_cmp++;
    if (count !== exp_c || out !== exp_o) begin
      n_bad++;
      $display("FAIL %s %s: count=%0d out=%0b expected count=%0d out=%0b",
               req, what, count, out, exp_c, exp_o);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: run still active, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // vector table: one fresh start per entry
    for (int i = 0; i < NV; i++) begin
      do_reset();
      do_load(VECS[i].m, VECS[i].n);
      adv(1 + int'(VECS[i].d));
      chk(req_of(VECS[i].m), $sformatf("vec %0d", i), VECS[i].c, VECS[i].o);
    end

    // R1 reset state and idle until first load
    do_reset();
    chk("R1", "after reset", 16'd0, 1'b0);
    adv(10);
    chk("R1", "idle with enable", 16'd0, 1'b0);

    // R2 loaded zero is full range
    do_reset();
    do_load(3'd0, 16'd0);
    adv(1);
    chk("R2", "start tick", 16'd0, 1'b0);
    adv(1);
    chk("R2", "first decrement", 16'd65535, 1'b0);
    adv(65534);
    chk("R2", "one before tc", 16'd1, 1'b0);
    adv(1);
    chk("R2", "tc at 65536", 16'd0, 1'b1);

    // R5 gate holds mode 0, no restart on rise
    do_reset();
    do_load(3'd0, 16'd10);
    adv(4);
    chk("R5", "mode0 running", 16'd7, 1'b0);
    gate = 1'b0;
    adv(5);
    chk("R5", "mode0 gate low hold", 16'd7, 1'b0);
    gate = 1'b1;
    adv(1);
    chk("R5", "mode0 gate rise no restart", 16'd6, 1'b0);

    // R6 one-shot free-runs, R11 gate retrigger
    do_reset();
    do_load(3'd1, 16'd6);
    adv(5);
    chk("R6", "one-shot running", 16'd2, 1'b0);
    gate = 1'b0;
    adv(1);
    chk("R6", "one-shot ignores gate level", 16'd1, 1'b0);
    gate = 1'b1;
    adv(1);
    chk("R6", "one-shot reaches zero", 16'd0, 1'b1);
    adv(1);
    chk("R11", "one-shot retriggered", 16'd6, 1'b0);

    // R5 rate mode gate hold, R11 restart
    do_reset();
    do_load(3'd2, 16'd5);
    adv(3);
    chk("R7", "rate running", 16'd3, 1'b0);
    gate = 1'b0;
    adv(2);
    chk("R5", "rate gate low hold", 16'd3, 1'b0);
    gate = 1'b1;
    adv(2);
    chk("R11", "rate restarted by gate", 16'd5, 1'b0);

    // R11 mode 5 retrigger
    do_reset();
    do_load(3'd5, 16'd3);
    adv(2);
    gate = 1'b0;
    adv(1);
    gate = 1'b1;
    adv(1);
    chk("R9", "hw strobe pulse", 16'd0, 1'b1);
    adv(1);
    chk("R11", "hw strobe retriggered", 16'd3, 1'b0);

    // R10 periodic rewrite deferred to reload
    do_reset();
    do_load(3'd2, 16'd4);
    adv(2);
    chk("R10", "rate before rewrite", 16'd3, 1'b0);
    do_load(3'd2, 16'd2);
    chk("R10", "rewrite no restart", 16'd2, 1'b0);
    adv(2);
    chk("R10", "reload uses new value", 16'd2, 1'b1);
    adv(2);
    chk("R10", "new period length", 16'd2, 1'b1);

    // R10 mode 0 rewrite restarts on next tick
    do_reset();
    do_load(3'd0, 16'd10);
    adv(3);
    chk("R10", "mode0 before rewrite", 16'd8, 1'b0);
    do_load(3'd0, 16'd20);
    chk("R10", "mode0 load tick still counts", 16'd7, 1'b0);
    adv(1);
    chk("R10", "mode0 restarted", 16'd20, 1'b0);

    // R9 strobe does not repeat after wrap
    do_reset();
    do_load(3'd4, 16'd1);
    adv(2);
    chk("R9", "sw strobe pulse", 16'd0, 1'b1);
    adv(65536);
    chk("R9", "no pulse after wrap", 16'd0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule